// File: doc/BRIEF.md
# Condition-Truncated Vector Element Sequencer

This block walks a vector operation through its element indices in strict ascending order, from 0 up to the requested vector length minus one. For each index it raises an issue request toward an execution unit. The unit hands back, in issue order and after any latency, a data result plus a 4-bit condition field. The sequencer picks one bit of that field and compares it with an expected sense. The first element that fails the comparison ends the run. The vector length is cut back at that point, and every element beyond it is discarded.

Results may come back well ahead of their turn. They wait in a four-entry in-order buffer and reach the register-file write port only once their own condition test has passed. When four elements are outstanding and uncommitted, issue stalls.

After a failure the block keeps accepting, and silently dropping, results for elements that were already issued. Once the last of them has returned it pulses done, so a new run never sees a stale result. A condition-only operation with meaningless data is still useful: the test and the truncation happen all the same.

Top module: `ffirst_seq`

## Requirements
- R1: Issue requests name indices 0, 1, 2, ... in order, never reach the loaded length, and never leave more than DEPTH (4) issued elements uncommitted; issue stalls while that limit is reached.
- R2: Commit writes occur in ascending index order starting at 0, with one write per element, and the written data is the result returned for that index.
- R3: An element passes when bit `cond_sel` (0 to 3) of its returned 4-bit condition equals `sense`. A `sense` of 1 passes on a set bit and a `sense` of 0 passes on a clear bit.
- R4: With `keep_fail` low, the first failing element is not written and the final length equals its index.
- R5: With `keep_fail` high, the first failing element is written and the final length equals its index plus one.
- R6: No element after the first failure is ever written, and no issue request follows a failure.
- R7: If every element passes, the final length equals the loaded length and all elements are written.
- R8: A start with length 0 produces a done pulse on the next cycle, with a final length of 0, no issue request and no write.
- R9: Done is a one-cycle pulse. After a failure it is withheld until every issued element's result has been returned, and those results are dropped.
- R10: After reset, done, write enable and issue request are low and the final length reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| vl_in | input | VL_W | Requested vector length |
| cond_sel | input | 2 | Index of the condition bit to test |
| sense | input | 1 | Bit value that counts as a pass |
| keep_fail | input | 1 | Include the failing element in the result |
| req_valid | output | 1 | Issue request for element `req_idx` |
| req_idx | output | VL_W | Index being issued |
| res_valid | input | 1 | Result for the oldest unreturned issued element |
| res_data | input | DW | Element data result |
| res_cond | input | 4 | Element condition field |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | VL_W | Element index being written |
| wr_data | output | DW | Data being written |
| final_vl | output | VL_W | Resulting vector length, valid from done onward |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest situation to reach is a failure that is found while several later elements are already issued and their results are still in flight. Here the block must drop those results and hold done back until they are all returned. The bench reaches it with a result-return model whose latency comes from the vector table. Long latencies fill the four-entry window so that issue stalls. A failure placed mid-vector then leaves up to three younger elements outstanding, and the bench checks that none of them is written and that done arrives only after the last one returns.

// File: rtl/ffirst_seq.sv
module ffirst_seq #(
  parameter int DW    = 16,
  parameter int VL_W  = 6,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic [1:0]      cond_sel,
  input  logic            sense,
  input  logic            keep_fail,
  output logic            req_valid,
  output logic [VL_W-1:0] req_idx,
  input  logic            res_valid,
  input  logic [DW-1:0]   res_data,
  input  logic [3:0]      res_cond,
  output logic            wr_en,
  output logic [VL_W-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic [VL_W-1:0] final_vl,
  output logic            done
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [VL_W-1:0] LIMIT = VL_W'(DEPTH);
  localparam logic [VL_W-1:0] ONE   = VL_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;

  st_t             st;
  logic [VL_W-1:0] vl_q, nxt, rcv, cmt;
  logic [1:0]      sel_q;
  logic            sense_q, keep_q;
  logic [DW-1:0]   buf_data [DEPTH];
  logic [3:0]      buf_cond [DEPTH];
  logic [DEPTH-1:0] buf_v;

  logic [VL_W-1:0] inflight;
  logic [AW-1:0]   hd, tl;
  logic            head_v, pass, fail, acc;

  assign inflight = nxt - cmt;
  assign hd       = cmt[AW-1:0];
  assign tl       = rcv[AW-1:0];
  assign head_v   = (st == S_RUN) && buf_v[hd];
  assign pass     = buf_cond[hd][sel_q] == sense_q;
  assign fail     = head_v && !pass;
  assign acc      = res_valid && (st != S_IDLE) && (rcv != nxt);

  assign req_valid = (st == S_RUN) && (nxt != vl_q) && (inflight < LIMIT) && !fail;
  assign req_idx   = nxt;
  assign wr_en     = head_v && (pass || keep_q);
  assign wr_idx    = cmt;
  assign wr_data   = buf_data[hd];

  always_ff @(posedge clk) begin
    if (acc && st == S_RUN) begin
      buf_data[tl] <= res_data;
      buf_cond[tl] <= res_cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vl_q     <= '0;
      nxt      <= '0;
      rcv      <= '0;
      cmt      <= '0;
      sel_q    <= '0;
      sense_q  <= 1'b0;
      keep_q   <= 1'b0;
      buf_v    <= '0;
      final_vl <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            vl_q    <= vl_in;
            sel_q   <= cond_sel;
            sense_q <= sense;
            keep_q  <= keep_fail;
            nxt     <= '0;
            rcv     <= '0;
            cmt     <= '0;
            buf_v   <= '0;
            if (vl_in == '0) begin
              final_vl <= '0;
              done     <= 1'b1;
            end else begin
              st <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (req_valid) nxt <= nxt + ONE;
          if (acc) rcv <= rcv + ONE;
          if (head_v) begin
            cmt       <= cmt + ONE;
            buf_v[hd] <= 1'b0;
          end
          if (acc) buf_v[tl] <= 1'b1;
          if (fail) begin
            buf_v    <= '0;
            final_vl <= cmt + (keep_q ? ONE : '0);
            if (nxt == rcv + (acc ? ONE : '0)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_DRAIN;
            end
          end else if (head_v && (cmt + ONE == vl_q)) begin
            final_vl <= vl_q;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_DRAIN: begin
          if (acc) begin
            rcv <= rcv + ONE;
            if (rcv + ONE == nxt) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= LIMIT);

  assert_req_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_idx < vl_q);

  assert_commit_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && st == S_RUN && $past(st) == S_RUN) |-> wr_idx == $past(wr_idx) + ONE);

  assert_no_late_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |-> (!wr_en && !req_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_final_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> final_vl <= vl_q);

endmodule

// File: tb/ffirst_seq_tb_top.sv
`timescale 1ns/1ps
module ffirst_seq_tb_top;

  localparam int DW = 16;
  localparam int VL_W = 6;
  localparam int NV = 9;
  localparam logic [5:0] NOFAIL = 6'd63;

  // {vl[6], sel[2], sense[1], keep[1], fail_at[6], lat[4]}
  localparam logic [19:0] VEC [NV] = '{
    {6'd8,  2'd0, 1'b1, 1'b0, NOFAIL, 4'd1},
    {6'd10, 2'd2, 1'b0, 1'b0, 6'd5,   4'd3},
    {6'd10, 2'd1, 1'b1, 1'b1, 6'd5,   4'd6},
    {6'd12, 2'd3, 1'b0, 1'b0, 6'd0,   4'd2},
    {6'd12, 2'd3, 1'b1, 1'b1, 6'd0,   4'd7},
    {6'd7,  2'd0, 1'b0, 1'b1, 6'd6,   4'd2},
    {6'd7,  2'd2, 1'b1, 1'b0, 6'd6,   4'd1},
    {6'd20, 2'd1, 1'b0, 1'b0, NOFAIL, 4'd9},
    {6'd1,  2'd0, 1'b1, 1'b0, NOFAIL, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vl_in = '0;
  logic [1:0] cond_sel = '0;
  logic sense = 1'b0, keep_fail = 1'b0;
  logic req_valid, wr_en, done;
  logic [VL_W-1:0] req_idx, wr_idx, final_vl;
  logic res_valid = 1'b0;
  logic [DW-1:0] res_data = '0, wr_data;
  logic [3:0] res_cond = '0;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ffirst_seq #(.DW(DW), .VL_W(VL_W), .DEPTH(4)) dut_i (
    .clk, .rst_n, .start, .vl_in, .cond_sel, .sense, .keep_fail,
    .req_valid, .req_idx, .res_valid, .res_data, .res_cond,
    .wr_en, .wr_idx, .wr_data, .final_vl, .done);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] edata(input int idx);
    return DW'(16'hC000 + idx * 7);
  endfunction

  function automatic logic [3:0] econd(input int idx, input int sel, input bit sns, input int fat);
    logic [3:0] c = 4'(idx) ^ 4'h5;
    c[sel] = (idx == fat) ? ~sns : sns;
    return c;
  endfunction

  task automatic run(input int vl, input int sel, input bit sns, input bit keep,
                     input int fat, input int lat, input bit want_full);
    int iss_cyc [64];
    int issued = 0, rtn = 0, nwr = 0, maxw = 0, t = 0;
    int exp_vl;
    bit seen = 0, order_ok = 1, data_ok = 1, req_ok = 1;
    exp_vl = (fat < vl) ? fat + int'(keep) : vl;
    @(negedge clk);
    start = 1'b1; vl_in = VL_W'(vl); cond_sel = 2'(sel); sense = sns; keep_fail = keep;
    @(negedge clk);
    start = 1'b0;
    while (!seen && t < 400) begin
      if (done) begin
        seen = 1;
      end else begin
        if (req_valid) begin
          if (int'(req_idx) != issued || int'(req_idx) >= vl) req_ok = 0;
          iss_cyc[issued] = cyc;
          issued++;
        end
        if (wr_en) begin
          if (int'(wr_idx) != nwr || nwr >= exp_vl) order_ok = 0;
          if (wr_data != edata(int'(wr_idx))) data_ok = 0;
          nwr++;
        end
        if (issued - nwr > maxw) maxw = issued - nwr;
        res_valid = 1'b0;
        if (rtn < issued && cyc >= iss_cyc[rtn] + lat + 1) begin
          res_valid = 1'b1;
          res_data = edata(rtn);
          res_cond = econd(rtn, sel, sns, fat);
          rtn++;
        end
        @(negedge clk);
        t++;
      end
    end
    res_valid = 1'b0;
    chk(seen, "R9 done seen", int'(seen), 1);
    chk(int'(final_vl) == exp_vl, (fat < vl) ? (keep ? "R5 final vl" : "R4 final vl") : "R7 final vl",
        int'(final_vl), exp_vl);
    chk(nwr == exp_vl, "R2 write count", nwr, exp_vl);
    chk(order_ok, "R2 R6 write order", int'(order_ok), 1);
    chk(data_ok, "R2 write data", int'(data_ok), 1);
    chk(req_ok && maxw <= 4, "R1 issue order and window", maxw, 4);
    if (want_full) chk(maxw == 4, "R1 issue stall at full window", maxw, 4);
    chk(rtn == issued, "R9 drain before done", rtn, issued);
    if (fat < vl) chk(sns == ~econd(fat, sel, sns, fat)[sel], "R3 fail sense", int'(sns), 1);
    @(negedge clk);
    chk(!done && !wr_en && !req_valid, "R6 R9 quiet after done", int'(done | wr_en | req_valid), 0);
  endtask

  always @(negedge clk) cyc++;

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !wr_en && !req_valid && final_vl == '0, "R10 reset state",
        int'(done | wr_en | req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: zero length
    start = 1'b1; vl_in = '0; cond_sel = 2'd1; sense = 1'b1; keep_fail = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8 done next cycle", int'(done), 1);
    chk(final_vl == '0, "R8 final vl zero", int'(final_vl), 0);
    chk(!req_valid && !wr_en, "R8 no issue or write", int'(req_valid | wr_en), 0);
    @(negedge clk);
    chk(!done, "R9 single pulse", int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v = VEC[i];
      run(int'(v[19:14]), int'(v[13:12]), v[11], v[10],
          int'(v[9:4]), int'(v[3:0]), v[3:0] >= 4'd6);
    end

    // R3 R5: failing first element inclusive, sense 0 on bit 2, short latency
    run(3, 2, 1'b0, 1'b1, 0, 0, 1'b0);
    // R7: long run, zero latency
    run(40, 3, 1'b1, 1'b0, 63, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule